// File: doc/BRIEF.md
# Four-Way Set-Associative Page Translation Cache

This block caches recent page translations. It maps an 8-bit virtual page number to a 6-bit physical page number. A lookup is answered combinationally, in the same cycle, from sixteen stored entries. The entries are arranged as four sets of four ways. The two low bits of the page number select a set. The remaining six bits are compared against the tag of every way in that set at once.

When a lookup misses, the surrounding logic resolves the translation by other means and hands it back through the fill port. The fill port writes the translation on the next clock edge. The entry is chosen in this order:
- a way that already holds the same tag;
- otherwise the lowest-numbered empty way;
- otherwise the way named by a per-set rotating pointer.

A single flush input discards every translation in one cycle.

Top module: `tlb_sa_cache`

## Requirements
- R1: The set index is page number bits [1:0] and the tag is bits [7:2]. A physical address is formed as {returned physical page, 6-bit page offset}. For example, page 0x0F stored as physical page 0x0D, with offset 0x14, gives physical address 0x354.
- R2: In the same cycle, `lkp_hit` is 1 exactly when the indexed set holds a valid way whose tag equals the lookup tag. On a hit, `lkp_ppn` carries that way's physical page. On a miss, `lkp_ppn` is 0.
- R3: A lookup whose set holds no valid way with a matching tag reports a miss. This includes a page whose set is full of other tags.
- R4: A fill is written on the rising clock edge while `fill_en` is 1. A lookup in the same cycle still sees the contents from before the fill. From the next cycle on, the filled page hits with the filled physical page.
- R5: A fill whose tag is already valid in its set overwrites that way. No set ever holds two valid ways with the same tag.
- R6: A fill with no matching tag takes the lowest-numbered invalid way of its set.
- R7: A fill into a full set with no matching tag replaces the way named by that set's 2-bit rotating pointer. The pointer then advances by one, modulo 4. Pointers change on no other fill.
- R8: When `flush_all` is 1 at a clock edge, every valid bit is cleared and any fill in that cycle is dropped. The rotating pointers keep their values.
- R9: Synchronous reset clears every valid bit and sets every rotating pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lkp_vpn | input | 8 | Virtual page number to translate |
| lkp_hit | output | 1 | Lookup hit, combinational |
| lkp_ppn | output | 6 | Physical page number on hit, else 0 |
| fill_en | input | 1 | Install a translation at the next edge |
| fill_vpn | input | 8 | Virtual page number being installed |
| fill_ppn | input | 6 | Physical page number being installed |
| flush_all | input | 1 | Invalidate every entry at the next edge |

## Verification
Lookup results are due in the same cycle as the lookup page number. The bench therefore drives `lkp_vpn` on the falling edge and samples one nanosecond later, before the next rising edge. A fill or flush changes state only at the following rising edge. Its effect is checked from the next falling edge onward. The one exception is a deliberate probe of the fill cycle itself, which must still show the old contents. After every phase of fills, a bench-side model of sets, ways and pointers predicts the outcome for all 256 page numbers, and the bench sweeps all of them.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VPN_W  = 8;
    localparam int PPN_W  = 6;
    localparam int WAYS   = 4;
    localparam int SETS   = 4;
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = VPN_W - IDX_W;
    localparam int WAY_W  = $clog2(WAYS);

    typedef logic [IDX_W-1:0] set_idx_t;
    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [PPN_W-1:0] ppn_t;
    typedef logic [WAY_W-1:0] way_t;

    function automatic set_idx_t idx_of(input logic [VPN_W-1:0] vpn);
        return vpn[IDX_W-1:0];
    endfunction

    function automatic tag_t tag_of(input logic [VPN_W-1:0] vpn);
        return vpn[VPN_W-1:IDX_W];
    endfunction
endpackage

// File: rtl/tlb_way_match.sv
module tlb_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    parameter int PPN_W = 6
) (
    input  logic [WAYS-1:0]             valid_i,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
    input  logic [WAYS-1:0][PPN_W-1:0]  ppns_i,
    input  logic [TAG_W-1:0]            key_i,
    output logic [WAYS-1:0]             match_o,
    output logic                        hit_o,
    output logic [PPN_W-1:0]            ppn_o
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match_o[w] = valid_i[w] && (tags_i[w] == key_i);
    end

    assign hit_o = |match_o;

    always_comb begin
        ppn_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match_o[w]) ppn_o = ppn_o | ppns_i[w];
        end
    end
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]  match_i,
    input  logic [WAYS-1:0]  valid_i,
    input  logic [WAY_W-1:0] rr_i,
    output logic [WAY_W-1:0] way_o,
    output logic             use_rr_o
);
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] hit_way;
    logic             any_free;

    always_comb begin
        free_way = '0;
        any_free = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) begin
                free_way = WAY_W'(w);
                any_free = 1'b1;
            end
        end
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match_i[w]) hit_way = WAY_W'(w);
        end
    end

    always_comb begin
        if (|match_i) begin
            way_o    = hit_way;
            use_rr_o = 1'b0;
        end else if (any_free) begin
            way_o    = free_way;
            use_rr_o = 1'b0;
        end else begin
            way_o    = rr_i;
            use_rr_o = 1'b1;
        end
    end
endmodule

// File: rtl/tlb_sa_cache.sv
module tlb_sa_cache
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] lkp_vpn,
    output logic             lkp_hit,
    output logic [PPN_W-1:0] lkp_ppn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             flush_all
);
    logic [WAYS-1:0]             valid_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
    logic [WAYS-1:0][PPN_W-1:0]  ppn_q   [SETS];
    way_t                        rr_q    [SETS];

    set_idx_t lkp_set, fill_set;
    tag_t     lkp_tag, fill_tag;

    assign lkp_set  = idx_of(lkp_vpn);
    assign lkp_tag  = tag_of(lkp_vpn);
    assign fill_set = idx_of(fill_vpn);
    assign fill_tag = tag_of(fill_vpn);

    logic [WAYS-1:0] lkp_match;
    tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_lkp_cmp (
        .valid_i (valid_q[lkp_set]),
        .tags_i  (tag_q[lkp_set]),
        .ppns_i  (ppn_q[lkp_set]),
        .key_i   (lkp_tag),
        .match_o (lkp_match),
        .hit_o   (lkp_hit),
        .ppn_o   (lkp_ppn)
    );

    logic [WAYS-1:0] fill_match;
    logic            fill_hit_unused;
    ppn_t            fill_ppn_unused;
    tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_fill_cmp (
        .valid_i (valid_q[fill_set]),
        .tags_i  (tag_q[fill_set]),
        .ppns_i  (ppn_q[fill_set]),
        .key_i   (fill_tag),
        .match_o (fill_match),
        .hit_o   (fill_hit_unused),
        .ppn_o   (fill_ppn_unused)
    );

    way_t fill_way;
    logic fill_use_rr;
    tlb_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .match_i  (fill_match),
        .valid_i  (valid_q[fill_set]),
        .rr_i     (rr_q[fill_set]),
        .way_o    (fill_way),
        .use_rr_o (fill_use_rr)
    );

    logic do_fill;
    assign do_fill = fill_en && !flush_all;

    for (genvar s = 0; s < SETS; s++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q[s] <= '0;
                rr_q[s]    <= '0;
            end else if (flush_all) begin
                valid_q[s] <= '0;
            end else if (do_fill && fill_set == set_idx_t'(s)) begin
                valid_q[s][fill_way] <= 1'b1;
                tag_q[s][fill_way]   <= fill_tag;
                ppn_q[s][fill_way]   <= fill_ppn;
                if (fill_use_rr) rr_q[s] <= rr_q[s] + 1'b1;
            end
        end

        assert_rr_advance_R7: assert property (@(posedge clk) disable iff (rst)
            (do_fill && fill_set == set_idx_t'(s) && fill_use_rr) |=> (rr_q[s] == $past(rr_q[s]) + 1'b1))
            else $error("R7 pointer did not advance");
        assert_rr_hold_R7: assert property (@(posedge clk) disable iff (rst)
            !(do_fill && fill_set == set_idx_t'(s) && fill_use_rr) |=> $stable(rr_q[s]))
            else $error("R7 pointer moved unexpectedly");
    end

    assert_single_match_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lkp_match))
        else $error("R5 duplicate tag in set");
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> !lkp_hit)
        else $error("R8 hit after flush");
    assert_fill_visible_R4: assert property (@(posedge clk) disable iff (rst)
        do_fill |=> ((lkp_vpn != $past(fill_vpn)) || (lkp_hit && lkp_ppn == $past(fill_ppn))))
        else $error("R4 filled page not visible");
    assert_miss_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !lkp_hit |-> (lkp_ppn == '0))
        else $error("R2 nonzero page on miss");
endmodule

// File: tb/sim_tlb_sa_cache.sv
`timescale 1ns/1ps
module sim_tlb_sa_cache;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] lkp_vpn;
    logic       lkp_hit;
    logic [5:0] lkp_ppn;
    logic       fill_en;
    logic [7:0] fill_vpn;
    logic [5:0] fill_ppn;
    logic       flush_all;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    tlb_sa_cache u0 (
        .clk(clk), .rst(rst), .lkp_vpn(lkp_vpn), .lkp_hit(lkp_hit), .lkp_ppn(lkp_ppn),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .flush_all(flush_all)
    );

    bit       m_v [4][4];
    bit [5:0] m_t [4][4];
    bit [5:0] m_p [4][4];
    bit [1:0] m_ptr [4];

    function automatic void model_reset();
        for (int s = 0; s < 4; s++) begin
            m_ptr[s] = 0;
            for (int w = 0; w < 4; w++) m_v[s][w] = 0;
        end
    endfunction

    function automatic void model_fill(input bit [7:0] vpn, input bit [5:0] ppn);
        int s;
        int way;
        s = vpn[1:0];
        way = -1;
        for (int w = 0; w < 4; w++)
            if (way < 0 && m_v[s][w] && m_t[s][w] == vpn[7:2]) way = w;
        for (int w = 0; w < 4; w++)
            if (way < 0 && !m_v[s][w]) way = w;
        if (way < 0) begin
            way = m_ptr[s];
            m_ptr[s] = m_ptr[s] + 2'd1;
        end
        m_v[s][way] = 1;
        m_t[s][way] = vpn[7:2];
        m_p[s][way] = ppn;
    endfunction

    function automatic void model_lookup(input bit [7:0] vpn, output bit hit, output bit [5:0] ppn);
        hit = 0;
        ppn = 0;
        for (int w = 0; w < 4; w++)
            if (m_v[vpn[1:0]][w] && m_t[vpn[1:0]][w] == vpn[7:2]) begin
                hit = 1;
                ppn = m_p[vpn[1:0]][w];
            end
    endfunction

    task automatic check_now(input bit [7:0] vpn, input string req);
        bit       eh;
        bit [5:0] ep;
        model_lookup(vpn, eh, ep);
        vectors++;
        if (lkp_hit !== eh || lkp_ppn !== ep) begin
            errors++;
            $display("FAIL %s vpn=%02h actual hit=%0b ppn=%02h expected hit=%0b ppn=%02h",
                     req, vpn, lkp_hit, lkp_ppn, eh, ep);
        end
    endtask

    task automatic sweep(input string req);
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            lkp_vpn = 8'(v);
            #1;
            check_now(8'(v), req);
        end
    endtask

    task automatic fill(input bit [7:0] vpn, input bit [5:0] ppn, input bit flush);
        @(negedge clk);
        fill_en = 1; fill_vpn = vpn; fill_ppn = ppn; flush_all = flush;
        @(negedge clk);
        fill_en = 0; flush_all = 0;
        if (flush) model_reset_valid();
        else model_fill(vpn, ppn);
    endtask

    function automatic void model_reset_valid();
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 4; w++) m_v[s][w] = 0;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; lkp_vpn = 0; fill_en = 0; fill_vpn = 0; fill_ppn = 0; flush_all = 0;
        model_reset();
        do_reset();
        sweep("R9 reset empties");

        // R1 example translation
        fill(8'h0F, 6'h0D, 0);
        lkp_vpn = 8'h0F;
        #1;
        check_now(8'h0F, "R1 index/tag");
        vectors++;
        if ({lkp_ppn, 6'h14} !== 12'h354) begin
            errors++;
            $display("FAIL R1 phys addr actual %03h expected 354", {lkp_ppn, 6'h14});
        end
        lkp_vpn = 8'h00;
        #0.5;
        check_now(8'h00, "R3 miss in set 0");

        // R4 same-cycle fill and lookup
        @(negedge clk);
        fill_en = 1; fill_vpn = 8'h55; fill_ppn = 6'h2A; lkp_vpn = 8'h55;
        #1;
        check_now(8'h55, "R4 old contents during fill");
        @(negedge clk);
        fill_en = 0;
        model_fill(8'h55, 6'h2A);
        #1;
        check_now(8'h55, "R4 new contents after edge");

        // R6/R7 fill six tags into every set
        for (int s = 0; s < 4; s++)
            for (int k = 0; k < 6; k++)
                fill({6'((k * 11 + s * 3) & 63), 2'(s)}, 6'((k * 7 + s * 13 + 1) & 63), 0);
        sweep("R6 R7 allocation");

        // R5 refill of a present tag
        fill({6'((5 * 11 + 1 * 3) & 63), 2'd1}, 6'h3F, 0);
        fill({6'((4 * 11 + 2 * 3) & 63), 2'd2}, 6'h01, 0);
        sweep("R5 overwrite in place");

        // R7 pointer continues past the wrap
        for (int k = 0; k < 5; k++) fill({6'(40 + k), 2'd2}, 6'(k + 20), 0);
        sweep("R7 rotation");

        // R8 flush beats fill; pointers kept
        fill(8'hA6, 6'h11, 1);
        sweep("R8 flush");
        for (int k = 0; k < 6; k++) fill({6'(k + 1), 2'd3}, 6'(k + 30), 0);
        sweep("R8 R6 refill after flush");

        // R9 reset mid-run clears valid and pointers
        do_reset();
        sweep("R9 reset mid-run");
        for (int k = 0; k < 5; k++) fill({6'(k + 9), 2'd0}, 6'(k + 2), 0);
        sweep("R9 R7 pointer restarted");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule